// File: doc/BRIEF.md
# Dual-Output PWM with Programmable Edge Actions

The block generates two pulse-width-modulated outputs from one shared time base. A counter of `CNT_W` bits advances on a tick from a power-of-two prescaler. It can count up, count down, count up and then down, or hold. Two compare values are matched against the counter. For each output, a small action table states what happens on three events: the counter at zero, the counter equal to compare A while rising, and the counter equal to compare B while rising. On each event the output can be driven low, driven high, inverted or left alone.

Software sets the block up through a 16-bit register port with a combinational read path. A compare value can be written straight into the active compare, or held in a shadow and copied across at a chosen point of the count. A trip input forces both outputs low. They stay low until software clears the latched trip flag.

Register addresses: 0 control, 1 period, 2 compare A, 3 compare B, 4 compare control, 5 action table of output 0, 6 action table of output 1, 7 trip flag, 8 counter (read only). Any other address reads 0.

Top module: `pwm_aq_top`

## Requirements
- R1: In up mode, on each tick the counter goes to 0 when it is at or above the period register, and otherwise adds one. A period register of P-1 therefore gives a cycle of P ticks. The counter reads at address 8.
- R2: Control bits 1:0 select the count mode: 0 up, 1 down, 2 up-down, 3 hold. In down mode the counter reloads the period register from 0. In up-down mode it turns downward at or above the period register and turns upward at 0. In hold mode it does not change.
- R3: Control bits 12:10 hold n. The counter steps once every 2^n clocks (n = 0 to 7) and stays stable between ticks.
- R4: Addresses 5 and 6 hold the action tables of outputs 0 and 1. Bits 1:0 apply to the zero event, bits 5:4 to the compare-A-rising event and bits 9:8 to the compare-B-rising event. The codes are 0 none, 1 drive low, 2 drive high, 3 invert. An output changes in the clock after its event tick.
- R5: When several events with a non-zero code arrive on the same tick, compare B wins over compare A, and compare A wins over zero. Compare events fire only on ticks where the counter is rising: up mode, or the upward leg of up-down mode. No event fires in hold mode.
- R6: With drive-high at zero and drive-low at a compare match in up mode, the output stays high for exactly the compare value in ticks per cycle. A compare of 0 gives an output that never goes high.
- R7: When the shadow bit of a compare is 0 (compare-control bit 4 for A, bit 6 for B), a write to that compare takes effect in the next clock.
- R8: When the shadow bit is 1, a write goes to the shadow only. The active value is loaded at the point chosen by compare-control bits 1:0 (A) or 3:2 (B): 0 at the zero event, 1 at the period event, 2 at either. Code 3 means the active value never loads.
- R9: A high trip input latches the trip flag (address 7, bit 0) in the next clock. While the flag is set, both outputs are 0. Writing 1 to bit 0 of address 7 clears the flag, unless trip is still high in that clock.
- R10: After reset, every register, the counter and both outputs are 0.
- R11: Control bits 15:14 are stored and read back, and they have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| trip_i | input | 1 | Trip request, forces outputs low |
| pwm_o | output | 2 | PWM outputs |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 3-bit prescaler field. The full divide range up to 128 is therefore reachable. It runs short periods (3 to 9) at divides of 1, 4 and 128, so that wraps and turns in every count mode occur many times. A behavioural model steps along with the block on every clock. Shadow loads at zero, at period, at either point and never are each compared against the readback of the active compare.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  typedef enum logic [1:0] {MODE_UP = 2'd0, MODE_DOWN = 2'd1, MODE_UPDN = 2'd2, MODE_HOLD = 2'd3} cnt_mode_e;
  typedef enum logic [1:0] {ACT_NONE = 2'd0, ACT_LOW = 2'd1, ACT_HIGH = 2'd2, ACT_FLIP = 2'd3} act_e;
  typedef enum logic [1:0] {LD_ZERO = 2'd0, LD_PRD = 2'd1, LD_BOTH = 2'd2, LD_NEVER = 2'd3} ld_pt_e;

  localparam int A_CTRL   = 0;
  localparam int A_PRD    = 1;
  localparam int A_CMPA   = 2;
  localparam int A_CMPB   = 3;
  localparam int A_CMPCTL = 4;
  localparam int A_ACT0   = 5;
  localparam int A_ACT1   = 6;
  localparam int A_TRIP   = 7;
  localparam int A_CNT    = 8;

  localparam int DIV_LSB = 10;
  localparam int SHD_LSB = 4;
endpackage

// File: rtl/pwm_aq_timebase.sv
module pwm_aq_timebase
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_mode_e        mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             up_o,
  output logic             zero_o,
  output logic             prd_o
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] mask;
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;

  assign one_sh = (PRE_W+1)'(1) << div_i;
  assign mask   = PRE_W'(one_sh - (PRE_W+1)'(1));
  assign run_o  = ((pre_q & mask) == mask) && (mode_i != MODE_HOLD);
  assign up_o   = (mode_i == MODE_UP) || ((mode_i == MODE_UPDN) && dir_q);
  assign zero_o = run_o && (cnt_q == '0);
  assign prd_o  = run_o && (cnt_q == prd_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (run_o) begin
        unique case (mode_i)
          MODE_UP: begin
            cnt_q <= (cnt_q >= prd_i) ? '0 : cnt_q + CNT_W'(1);
            dir_q <= 1'b1;
          end
          MODE_DOWN: begin
            cnt_q <= (cnt_q == '0) ? prd_i : cnt_q - CNT_W'(1);
            dir_q <= 1'b1;
          end
          MODE_UPDN: begin
            if (dir_q) begin
              if (cnt_q >= prd_i) begin
                dir_q <= 1'b0;
                cnt_q <= (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
              end else begin
                cnt_q <= cnt_q + CNT_W'(1);
              end
            end else if (cnt_q == '0) begin
              dir_q <= 1'b1;
              cnt_q <= (prd_i == '0) ? '0 : CNT_W'(1);
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_aq_cmp.sv
module pwm_aq_cmp
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             shadow_i,
  input  ld_pt_e           ld_i,
  input  logic             zero_i,
  input  logic             prd_i,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] shd_q;
  logic             load;

  always_comb begin
    unique case (ld_i)
      LD_ZERO: load = zero_i;
      LD_PRD:  load = prd_i;
      LD_BOTH: load = zero_i | prd_i;
      default: load = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
      act_o <= '0;
    end else begin
      if (wr_i) shd_q <= wdata_i;
      if (wr_i && !shadow_i) act_o <= wdata_i;
      else if (shadow_i && load) act_o <= shd_q;
    end
  end
endmodule

// File: rtl/pwm_aq_action.sv
module pwm_aq_action
  import pwm_aq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] z_ctl_i,
  input  logic [1:0] a_ctl_i,
  input  logic [1:0] b_ctl_i,
  input  logic       ev_z_i,
  input  logic       ev_a_i,
  input  logic       ev_b_i,
  output logic       q_o
);
  act_e code;

  // B over A over zero; an event coded none does not mask a lower one
  always_comb begin
    if (ev_b_i && b_ctl_i != 2'd0)      code = act_e'(b_ctl_i);
    else if (ev_a_i && a_ctl_i != 2'd0) code = act_e'(a_ctl_i);
    else if (ev_z_i && z_ctl_i != 2'd0) code = act_e'(z_ctl_i);
    else                                code = ACT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else begin
      unique case (code)
        ACT_LOW:  q_o <= 1'b0;
        ACT_HIGH: q_o <= 1'b1;
        ACT_FLIP: q_o <= ~q_o;
        default:  q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/pwm_aq_top.sv
module pwm_aq_top
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              trip_i,
  output logic [1:0]        pwm_o
);
  localparam int NCH = 2;

  logic [15:0]      ctrl_q, cmpctl_q;
  logic [15:0]      act_q [NCH];
  logic [CNT_W-1:0] prd_q, cnt;
  logic [CNT_W-1:0] cmp_act [NCH];
  logic [NCH-1:0]   ev_cmp, raw;
  logic             run, up, ev_zero, ev_prd, trip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      prd_q    <= '0;
      cmpctl_q <= '0;
      for (int i = 0; i < NCH; i++) act_q[i] <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_W'(A_CTRL))   ctrl_q   <= wdata_i;
      if (addr_i == ADDR_W'(A_PRD))    prd_q    <= wdata_i[CNT_W-1:0];
      if (addr_i == ADDR_W'(A_CMPCTL)) cmpctl_q <= wdata_i;
      for (int i = 0; i < NCH; i++)
        if (addr_i == ADDR_W'(A_ACT0 + i)) act_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      trip_q <= 1'b0;
    else if (trip_i)  trip_q <= 1'b1;
    else if (wr_en_i && addr_i == ADDR_W'(A_TRIP) && wdata_i[0]) trip_q <= 1'b0;
  end

  pwm_aq_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tb (
    .clk_i, .rst_ni,
    .mode_i (cnt_mode_e'(ctrl_q[1:0])),
    .div_i  (ctrl_q[DIV_LSB +: DIV_W]),
    .prd_i  (prd_q),
    .cnt_o  (cnt),
    .run_o  (run),
    .up_o   (up),
    .zero_o (ev_zero),
    .prd_o  (ev_prd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    pwm_aq_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk_i, .rst_ni,
      .wr_i     (wr_en_i && addr_i == ADDR_W'(A_CMPA + g)),
      .wdata_i  (wdata_i[CNT_W-1:0]),
      .shadow_i (cmpctl_q[SHD_LSB + 2*g]),
      .ld_i     (ld_pt_e'(cmpctl_q[2*g +: 2])),
      .zero_i   (ev_zero),
      .prd_i    (ev_prd),
      .act_o    (cmp_act[g])
    );
    assign ev_cmp[g] = run && up && (cnt == cmp_act[g]);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    pwm_aq_action u_act (
      .clk_i, .rst_ni,
      .z_ctl_i (act_q[g][1:0]),
      .a_ctl_i (act_q[g][5:4]),
      .b_ctl_i (act_q[g][9:8]),
      .ev_z_i  (ev_zero),
      .ev_a_i  (ev_cmp[0]),
      .ev_b_i  (ev_cmp[1]),
      .q_o     (raw[g])
    );
  end

  assign pwm_o = raw & {NCH{~trip_q}};

  always_comb begin
    unique case (addr_i)
      ADDR_W'(A_CTRL):   rdata_o = ctrl_q;
      ADDR_W'(A_PRD):    rdata_o = 16'(prd_q);
      ADDR_W'(A_CMPA):   rdata_o = 16'(cmp_act[0]);
      ADDR_W'(A_CMPB):   rdata_o = 16'(cmp_act[1]);
      ADDR_W'(A_CMPCTL): rdata_o = cmpctl_q;
      ADDR_W'(A_ACT0):   rdata_o = act_q[0];
      ADDR_W'(A_ACT1):   rdata_o = act_q[1];
      ADDR_W'(A_TRIP):   rdata_o = {15'd0, trip_q};
      ADDR_W'(A_CNT):    rdata_o = 16'(cnt);
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trip_i,
  input logic              trip_q_i,
  input logic [1:0]        pwm_o_i,
  input logic [1:0]        mode_i,
  input logic              run_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  prd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       wdata_i,
  input logic              shadow_a_i,
  input logic [CNT_W-1:0]  cmp_a_i
);
  // R9
  trip_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_q_i |-> pwm_o_i == 2'b00);

  // R9
  trip_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |=> trip_q_i);

  // R2
  hold_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd3 |=> $stable(cnt_i));

  // R3
  no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_i));

  // R1
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mode_i == 2'd0 && cnt_i >= prd_i) |=> cnt_i == '0);

  // R7
  cmp_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(2) && !shadow_a_i) |=> cmp_a_i == $past(wdata_i[CNT_W-1:0]));
endmodule

bind pwm_aq_top pwm_aq_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trip_i     (trip_i),
  .trip_q_i   (trip_q),
  .pwm_o_i    (pwm_o),
  .mode_i     (ctrl_q[1:0]),
  .run_i      (run),
  .cnt_i      (cnt),
  .prd_i      (prd_q),
  .wr_i       (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .shadow_a_i (cmpctl_q[4]),
  .cmp_a_i    (cmp_act[0])
);

// File: tb/pwm_aq_top_tb.sv
module pwm_aq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = 4'd8;
  logic [15:0] wdata = '0;
  logic        trip = 1'b0;
  logic [15:0] rdata;
  logic [1:0]  pwm;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_aq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .trip_i(trip), .pwm_o(pwm)
  );

  // behavioural reference
  int m_ctrl, m_prd, m_cmpctl, m_cnt, m_dir, m_pre, m_trip;
  int m_cmp[2], m_sh[2], m_act[2], m_pwm[2];

  always @(posedge clk or negedge rst_n) begin
    int mode, dv, mask, a, c, sh, ld;
    bit rn, upf, ez, ep, w;
    bit ec[2];
    if (!rst_n) begin
      m_ctrl = 0; m_prd = 0; m_cmpctl = 0; m_cnt = 0; m_dir = 1; m_pre = 0; m_trip = 0;
      for (int i = 0; i < 2; i++) begin m_cmp[i] = 0; m_sh[i] = 0; m_act[i] = 0; m_pwm[i] = 0; end
    end else begin
      mode = m_ctrl & 3;
      dv   = (m_ctrl >> 10) & 7;
      mask = (1 << dv) - 1;
      rn   = ((m_pre & mask) == mask) && mode != 3;
      upf  = (mode == 0) || (mode == 2 && m_dir == 1);
      ez   = rn && m_cnt == 0;
      ep   = rn && m_cnt == m_prd;
      for (int i = 0; i < 2; i++) ec[i] = rn && upf && m_cnt == m_cmp[i];
      for (int o = 0; o < 2; o++) begin
        a = m_act[o]; c = 0;
        if (ec[1] && ((a >> 8) & 3) != 0)      c = (a >> 8) & 3;
        else if (ec[0] && ((a >> 4) & 3) != 0) c = (a >> 4) & 3;
        else if (ez && (a & 3) != 0)           c = a & 3;
        if (c == 1) m_pwm[o] = 0;
        else if (c == 2) m_pwm[o] = 1;
        else if (c == 3) m_pwm[o] = 1 - m_pwm[o];
      end
      for (int ch = 0; ch < 2; ch++) begin
        sh = (m_cmpctl >> (4 + 2*ch)) & 1;
        ld = (m_cmpctl >> (2*ch)) & 3;
        w  = wr && addr == 4'(2 + ch);
        if (w && sh == 0) m_cmp[ch] = wdata;
        else if (sh == 1 && ((ld == 0 && ez) || (ld == 1 && ep) || (ld == 2 && (ez || ep))))
          m_cmp[ch] = m_sh[ch];
        if (w) m_sh[ch] = wdata;
      end
      if (rn) begin
        if (mode == 0) begin m_cnt = (m_cnt >= m_prd) ? 0 : m_cnt + 1; m_dir = 1; end
        else if (mode == 1) begin m_cnt = (m_cnt == 0) ? m_prd : m_cnt - 1; m_dir = 1; end
        else if (m_dir == 1) begin
          if (m_cnt >= m_prd) begin m_dir = 0; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else m_cnt = m_cnt + 1;
        end else if (m_cnt == 0) begin m_dir = 1; m_cnt = (m_prd == 0) ? 0 : 1; end
        else m_cnt = m_cnt - 1;
      end
      m_pre = (m_pre + 1) % 128;
      if (trip) m_trip = 1;
      else if (wr && addr == 4'd7 && wdata[0]) m_trip = 0;
      if (wr) begin
        case (addr)
          4'd0: m_ctrl = wdata;
          4'd1: m_prd = wdata;
          4'd4: m_cmpctl = wdata;
          4'd5: m_act[0] = wdata;
          4'd6: m_act[1] = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_ctrl;
      1: return m_prd;
      2: return m_cmp[0];
      3: return m_cmp[1];
      4: return m_cmpctl;
      5: return m_act[0];
      6: return m_act[1];
      7: return m_trip;
      8: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  bit mon_en = 0;
  always @(negedge clk) begin
    int ep;
    if (rst_n && mon_en) begin
      ep = (m_trip ? 0 : (m_pwm[1] << 1) | m_pwm[0]);
      check(int'(pwm) == ep, "R4/R5 pwm outputs", int'(pwm), ep);
      if (!wr && addr == 4'd8) check(int'(rdata) == m_cnt, "R1/R2/R3 counter", int'(rdata), m_cnt);
    end
  end

  task automatic wr_reg(int a, int d);
    @(posedge clk); #1;
    wr = 1; addr = 4'(a); wdata = 16'(d);
    @(posedge clk); #1;
    wr = 0; addr = 4'd8;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_rd(int a, string req);
    int e;
    @(posedge clk); #1;
    addr = 4'(a);
    @(negedge clk);
    e = exp_rd(a);
    check(int'(rdata) == e, req, int'(rdata), e);
    @(posedge clk); #1;
    addr = 4'd8;
  endtask

  task automatic duty(int o, int n, int exp, string req);
    int hi = 0;
    @(posedge clk); #1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm[o]) hi++;
    end
    check(hi == exp, req, hi, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #23 rst_n = 1'b1;
    // R10 reset state, checked against literals
    for (int a = 0; a < 9; a++) begin
      @(posedge clk); #1 addr = 4'(a);
      @(negedge clk);
      check(rdata == 16'd0, "R10 reset register", int'(rdata), 0);
    end
    check(pwm == 2'b00, "R10 reset outputs", int'(pwm), 0);
    @(posedge clk); #1 addr = 4'd8;
    mon_en = 1;

    // R6 typical set-at-zero / clear-at-compare, period 10
    wr_reg(1, 9);
    wr_reg(2, 3);
    wr_reg(3, 7);
    wr_reg(5, 'h012);
    wr_reg(6, 'h102);
    chk_rd(2, "R7 compare A immediate");
    chk_rd(3, "R7 compare B immediate");
    run(25);
    duty(0, 10, 3, "R6 duty A");
    duty(1, 10, 7, "R6 duty B");
    wr_reg(2, 0);
    run(12);
    duty(0, 20, 0, "R6 zero compare gives 0%");

    // R11 emulation bits stored, counting unchanged
    wr_reg(0, 'h8000);
    chk_rd(0, "R11 control readback");
    run(15);
    duty(1, 10, 7, "R11 no effect on duty");

    // R8 shadow load at zero
    wr_reg(4, 'h10);
    wr_reg(2, 5);
    chk_rd(2, "R8 shadow not yet active");
    run(12);
    chk_rd(2, "R8 loaded at zero");
    duty(0, 10, 5, "R8 new duty after zero load");
    // load at period
    wr_reg(4, 'h11);
    wr_reg(2, 2);
    run(12);
    chk_rd(2, "R8 loaded at period");
    // load at either
    wr_reg(4, 'h12);
    wr_reg(2, 6);
    run(12);
    chk_rd(2, "R8 loaded at either point");
    // never load: write is ignored by the active compare
    wr_reg(4, 'h13);
    wr_reg(2, 1);
    run(40);
    chk_rd(2, "R8 frozen load ignores write");
    check(int'(pwm[0]) == (m_trip ? 0 : m_pwm[0]), "R8 output after frozen write", int'(pwm[0]), m_pwm[0]);
    duty(0, 10, 6, "R8 duty kept with frozen load");
    // shadow B, immediate A back
    wr_reg(4, 'h40);
    wr_reg(3, 4);
    run(12);
    chk_rd(3, "R8 compare B loaded at zero");

    // R5 priority: all events coincide at zero
    wr_reg(2, 0);
    wr_reg(3, 0);
    run(12);
    wr_reg(5, 'h312);
    wr_reg(6, 'h012);
    run(40);
    wr_reg(5, 'h022);
    run(30);

    // R2 down mode and up-down mode, R3 divides
    wr_reg(5, 'h012);
    wr_reg(6, 'h302);
    wr_reg(2, 2);
    wr_reg(3, 3);
    wr_reg(1, 5);
    wr_reg(0, 'h0001);
    run(30);
    wr_reg(0, 'h0002);
    run(40);
    wr_reg(0, 'h0802);
    run(120);
    wr_reg(1, 3);
    wr_reg(0, 'h1C02);
    run(1600);
    wr_reg(0, 'h1C00);
    run(1100);
    wr_reg(0, 'h0003);
    run(30);
    chk_rd(8, "R2 hold counter");
    wr_reg(1, 0);
    wr_reg(0, 'h0002);
    run(20);
    wr_reg(1, 7);
    wr_reg(0, 'h0000);
    run(30);

    // R9 trip
    @(posedge clk); #1 trip = 1;
    @(posedge clk); #1 trip = 0;
    run(10);
    chk_rd(7, "R9 trip flag set");
    check(pwm == 2'b00, "R9 outputs forced low", int'(pwm), 0);
    @(posedge clk); #1 trip = 1;
    wr = 1; addr = 4'd7; wdata = 16'd1;
    @(posedge clk); #1 trip = 0; wr = 0; addr = 4'd8;
    chk_rd(7, "R9 clear loses to active trip");
    wr_reg(7, 1);
    chk_rd(7, "R9 trip flag cleared");
    run(20);

    mon_en = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule